// File: doc/BRIEF.md
# GPIO Pad Event and Interrupt Unit

This block serves a bank of general-purpose pads (up to 32, set by a parameter) that share one interrupt line. Each pad has its own configuration word. The word holds the output drive value, separate disable bits for the transmit and receive buffers, a function-mode field, an input inversion bit and a 2-bit event selector. Each pad input passes through a two-flop synchronizer. An optional inversion follows, and then an event detector that recognises active levels, single edges or both edges. Each detected event sets a sticky status bit for that pad. The interrupt line is the OR of all status bits whose per-pad enable bit is also set.

Software reaches all state through a simple register port. A write takes effect on the clock edge where it is presented. A read is returned on `reg_rdata_o` one cycle after `reg_rd_i`. Address bit 5 selects the region. When it is 0, bits 4:0 index a pad configuration word. When it is 1, the low bits pick a shared register: 0 is the event status (write 1 to clear), 1 is the interrupt enable mask, and 2 is the read-only pad value.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, every configuration word reads 0x04000100 (events off, transmit disabled) while the pad inputs are low. The status, the enable mask and `irq_o` are all zero.
- R2: Level mode is selector 0 (bits 26:25 of the configuration word). While the qualified input is 1, the status bit is set on every cycle. A write-1 clear therefore does not hold while the level stays active.
- R3: Single-edge mode is selector 1. With inversion off (bit 23 = 0), a 0-to-1 input change sets status. With inversion on, only a 1-to-0 change sets status.
- R4: Both-edge mode is selector 3. A rising or a falling input change sets status.
- R5: Level mode with inversion on sets status while the pad input is low. It stops doing so once the input is high.
- R6: No event is produced in any of these cases: selector 2, a nonzero mode field (bits 13:10), or receive disable (bit 9) set.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a set and a clear meet in the same cycle, the bit is set.
- R8: `irq_o` is 1 exactly when some pad has both its status bit and its enable bit set. It follows that condition one cycle later.
- R9: The pad value register bit is the drive value when transmit is enabled (bit 8 = 0). Otherwise it is the synchronized input. Configuration bit 1 reads the synchronized input, and it reads 0 while receive is disabled.
- R10: `pad_o` carries the drive bit (bit 0). `pad_oe_o` is 1 only when transmit is enabled and the mode field is zero.
- R11: A pad input change sets its status bit on the third rising edge after the change. `irq_o` follows on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NUM_PADS | Asynchronous pad inputs |
| pad_o | output | NUM_PADS | Pad drive values |
| pad_oe_o | output | NUM_PADS | Pad output enables |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register address (region bit plus index) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A pad change is due in the status register three rising edges after the bench drives it. `irq_o` is due one edge after that. The bench checks `irq_o` just after the third edge, where it must still be low, and again just after the fourth edge. Every read is queued with its expected value when it is issued. The monitor pops the queue on the falling edge that follows the capturing rising edge, which is where the registered read data is due. Other stimuli are followed by a settling wait of at least four cycles before any result is read back.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int CFG_W     = 32;
  localparam int B_DRIVE   = 0;
  localparam int B_RXST    = 1;
  localparam int B_TXDIS   = 8;
  localparam int B_RXDIS   = 9;
  localparam int B_MODE_LO = 10;
  localparam int MODE_W    = 4;
  localparam int B_INV     = 23;
  localparam int B_SEL_LO  = 25;

  localparam int G_STATUS = 0;
  localparam int G_ENABLE = 1;
  localparam int G_VALUE  = 2;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } ev_sel_e;

  typedef struct packed {
    ev_sel_e           sel;
    logic              inv;
    logic [MODE_W-1:0] mode;
    logic              rxdis;
    logic              txdis;
    logic              drive;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{sel: EV_OFF, inv: 1'b0, mode: '0,
                                     rxdis: 1'b0, txdis: 1'b1, drive: 1'b0};

  function automatic logic [CFG_W-1:0] cfg_pack(pad_cfg_t c, logic rx);
    logic [CFG_W-1:0] w;
    w = '0;
    w[B_DRIVE]              = c.drive;
    w[B_RXST]               = rx;
    w[B_TXDIS]              = c.txdis;
    w[B_RXDIS]              = c.rxdis;
    w[B_MODE_LO +: MODE_W]  = c.mode;
    w[B_INV]                = c.inv;
    w[B_SEL_LO +: 2]        = c.sel;
    return w;
  endfunction

  function automatic pad_cfg_t cfg_unpack(logic [CFG_W-1:0] w);
    pad_cfg_t c;
    c.drive = w[B_DRIVE];
    c.txdis = w[B_TXDIS];
    c.rxdis = w[B_RXDIS];
    c.mode  = w[B_MODE_LO +: MODE_W];
    c.inv   = w[B_INV];
    c.sel   = ev_sel_e'(w[B_SEL_LO +: 2]);
    return c;
  endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[k] <= '0;
        else     chain_q[k] <= chain_q[k-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rx_i,
  input  pad_cfg_t cfg_i,
  output logic     evt_o
);

  logic q;
  logic q_d;
  logic hit;
  logic armed;

  assign q = rx_i ^ cfg_i.inv;

  always_ff @(posedge clk) begin
    if (rst) q_d <= 1'b0;
    else     q_d <= q;
  end

  always_comb begin
    unique case (cfg_i.sel)
      EV_LEVEL: hit = q;
      EV_EDGE:  hit = q & ~q_d;
      EV_BOTH:  hit = q ^ q_d;
      default:  hit = 1'b0;
    endcase
  end

  assign armed = (cfg_i.mode == '0) & ~cfg_i.rxdis;
  assign evt_o = armed & hit;

  // R6
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_i.mode != '0) || cfg_i.rxdis) |-> !evt_o);

  // R6
  sel_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.sel == EV_OFF) |-> !evt_o);

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NUM_PADS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] set_i,
  input  logic                clr_we_i,
  input  logic [NUM_PADS-1:0] clr_mask_i,
  input  logic                en_we_i,
  input  logic [NUM_PADS-1:0] en_data_i,
  output logic [NUM_PADS-1:0] status_o,
  output logic [NUM_PADS-1:0] enable_o,
  output logic                irq_o
);

  logic [NUM_PADS-1:0] status_q;
  logic [NUM_PADS-1:0] enable_q;
  logic [NUM_PADS-1:0] clr_eff;
  logic                irq_q;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_i;
      if (en_we_i) enable_q <= en_data_i;
      irq_q    <= |(status_q & enable_q);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we_i |=> ((status_q & $past(clr_mask_i & ~set_i)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(|(status_q & enable_q)));

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_PADS < 4) ? 2 : $clog2(NUM_PADS),
  localparam int ADDR_W     = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] pad_oe_o,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [CFG_W-1:0]    reg_wdata_i,
  output logic [CFG_W-1:0]    reg_rdata_o,
  output logic                irq_o
);

  logic [IDX_W-1:0]    idx;
  logic                glb;
  logic [NUM_PADS-1:0] rx_sync;
  logic [NUM_PADS-1:0] rx_seen;
  logic [NUM_PADS-1:0] evt;
  logic [NUM_PADS-1:0] pad_val;
  logic [NUM_PADS-1:0] status;
  logic [NUM_PADS-1:0] enable;
  pad_cfg_t            cfg_q [NUM_PADS];
  logic [CFG_W-1:0]    rdata_q;

  assign idx = reg_addr_i[IDX_W-1:0];
  assign glb = reg_addr_i[ADDR_W-1];

  gpio_evt_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_i),
    .q_o (rx_sync)
  );

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      always_ff @(posedge clk) begin
        if (rst)
          cfg_q[i] <= CFG_RESET;
        else if (reg_wr_i && !glb && (idx == IDX_W'(i)))
          cfg_q[i] <= cfg_unpack(reg_wdata_i);
      end

      assign rx_seen[i]  = rx_sync[i] & ~cfg_q[i].rxdis;
      assign pad_o[i]    = cfg_q[i].drive;
      assign pad_oe_o[i] = ~cfg_q[i].txdis & (cfg_q[i].mode == '0);
      assign pad_val[i]  = cfg_q[i].txdis ? rx_seen[i] : cfg_q[i].drive;

      gpio_evt_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .rx_i  (rx_seen[i]),
        .cfg_i (cfg_q[i]),
        .evt_o (evt[i])
      );
    end
  endgenerate

  gpio_evt_status #(.NUM_PADS(NUM_PADS)) u_status (
    .clk        (clk),
    .rst        (rst),
    .set_i      (evt),
    .clr_we_i   (reg_wr_i && glb && (idx == IDX_W'(G_STATUS))),
    .clr_mask_i (reg_wdata_i[NUM_PADS-1:0]),
    .en_we_i    (reg_wr_i && glb && (idx == IDX_W'(G_ENABLE))),
    .en_data_i  (reg_wdata_i[NUM_PADS-1:0]),
    .status_o   (status),
    .enable_o   (enable),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      if (!glb) begin
        if (int'(idx) < NUM_PADS) rdata_q <= cfg_pack(cfg_q[idx], rx_seen[idx]);
        else                      rdata_q <= '0;
      end else begin
        case (int'(idx))
          G_STATUS: rdata_q <= CFG_W'(status);
          G_ENABLE: rdata_q <= CFG_W'(enable);
          G_VALUE:  rdata_q <= CFG_W'(pad_val);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;

  // R10
  oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && !glb && (reg_wdata_i[B_MODE_LO +: MODE_W] != '0) && (int'(idx) < NUM_PADS))
      |=> !pad_oe_o[$past(idx)]);

endmodule

// File: tb/sim_gpio_evt_unit.sv
module sim_gpio_evt_unit;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pad_i = '0;
  logic [N-1:0]  pad_o, pad_oe_o;
  logic          reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [5:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];
  logic rd_d = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_unit #(.NUM_PADS(N)) u0 (
    .clk(clk), .rst(rst), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  localparam logic [5:0] A_ST  = 6'h20;
  localparam logic [5:0] A_EN  = 6'h21;
  localparam logic [5:0] A_VAL = 6'h22;

  function automatic logic [5:0] a_cfg(int p);
    return {1'b0, 5'(p)};
  endfunction

  function automatic logic [31:0] cfgw(int sel, bit inv, bit txd, bit rxd, int mode, bit drv);
    logic [31:0] w;
    w = '0;
    w[26:25] = 2'(sel);
    w[23]    = inv;
    w[13:10] = 4'(mode);
    w[9]     = rxd;
    w[8]     = txd;
    w[0]     = drv;
    return w;
  endfunction

  // monitor: pops the scoreboard when registered read data is due
  always @(posedge clk) rd_d <= reg_rd_i;
  always @(negedge clk) begin
    if (rd_d) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if ((reg_rdata_o & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: got %h expected %h (mask %h)", it.tag, reg_rdata_o, it.exp, it.mask);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, logic [31:0] m, string tag);
    sb_item_t it;
    it.exp = e; it.mask = m; it.tag = tag;
    sb.push_back(it);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  task automatic chk(logic [31:0] got, logic [31:0] e, string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(a_cfg(0), 32'h0400_0100, '1, "R1 cfg reset");
    rd(A_ST, 0, '1, "R1 status reset");
    rd(A_EN, 0, '1, "R1 enable reset");
    chk(irq_o, 0, "R1 irq reset");
    chk(pad_oe_o, 0, "R1 oe reset");

    // R3 rising edge, R11/R8 latency
    wr(A_EN, 32'h8);
    wr(a_cfg(3), cfgw(1, 0, 1, 0, 0, 0));
    idle(2);
    pad_i[3] = 1'b1;
    idle(3);
    chk(irq_o, 0, "R11 irq low after third edge");
    idle(1);
    chk(irq_o, 1, "R11 irq high after fourth edge");
    rd(A_ST, 32'h8, 32'h8, "R3 rising edge status");
    // R7 write 0 keeps, write 1 clears
    wr(A_ST, 0);
    rd(A_ST, 32'h8, 32'h8, "R7 write 0 keeps bit");
    wr(A_ST, 32'h8);
    rd(A_ST, 0, 32'h8, "R7 write 1 clears edge bit");
    idle(2);
    chk(irq_o, 0, "R8 irq drops after clear");

    // R3 falling edge via inversion
    pad_i[5] = 1'b1;
    idle(4);
    wr(a_cfg(5), cfgw(1, 1, 1, 0, 0, 0));
    idle(3);
    rd(A_ST, 0, 32'h20, "R3 inverted edge ignores rise");
    pad_i[5] = 1'b0;
    idle(4);
    rd(A_ST, 32'h20, 32'h20, "R3 inverted edge catches fall");
    wr(A_ST, 32'h20);

    // R4 both edges
    wr(a_cfg(7), cfgw(3, 0, 1, 0, 0, 0));
    idle(2);
    pad_i[7] = 1'b1;
    idle(4);
    rd(A_ST, 32'h80, 32'h80, "R4 rise sets");
    wr(A_ST, 32'h80);
    rd(A_ST, 0, 32'h80, "R4 cleared");
    pad_i[7] = 1'b0;
    idle(4);
    rd(A_ST, 32'h80, 32'h80, "R4 fall sets");

    // R8 enable masking
    chk(irq_o, 0, "R8 masked status gives no irq");
    wr(A_EN, 32'h88);
    idle(2);
    chk(irq_o, 1, "R8 enabled status raises irq");
    wr(A_ST, 32'h80);
    idle(2);
    chk(irq_o, 0, "R8 irq low after clear");
    wr(A_EN, 0);

    // R2 level high, set wins over clear
    wr(a_cfg(9), cfgw(0, 0, 1, 0, 0, 0));
    pad_i[9] = 1'b1;
    idle(4);
    rd(A_ST, 32'h200, 32'h200, "R2 level sets");
    wr(A_ST, 32'h200);
    rd(A_ST, 32'h200, 32'h200, "R2 R7 active level resets bit after clear");
    pad_i[9] = 1'b0;
    idle(4);
    wr(A_ST, 32'h200);
    rd(A_ST, 0, 32'h200, "R2 clear sticks once level gone");

    // R5 low level
    wr(a_cfg(10), cfgw(0, 1, 1, 0, 0, 0));
    idle(2);
    rd(A_ST, 32'h400, 32'h400, "R5 low level sets");
    pad_i[10] = 1'b1;
    idle(4);
    wr(A_ST, 32'h400);
    rd(A_ST, 0, 32'h400, "R5 high input stops low level");

    // R6 suppressed events
    wr(a_cfg(12), cfgw(2, 0, 1, 0, 0, 0));
    wr(a_cfg(13), cfgw(3, 0, 0, 0, 1, 0));
    wr(a_cfg(14), cfgw(3, 0, 1, 1, 0, 0));
    idle(2);
    pad_i[14:12] = 3'b111;
    idle(4);
    rd(a_cfg(14), cfgw(3, 0, 1, 1, 0, 0), '1, "R9 rx state reads 0 when rx disabled");
    chk(pad_oe_o[13], 0, "R10 oe off in non-GPIO mode");
    pad_i[14:12] = 3'b000;
    idle(4);
    rd(A_ST, 0, 32'h7000, "R6 no events when off, moded, rx disabled");

    // R9 / R10 pad value and drive
    wr(a_cfg(20), cfgw(2, 0, 0, 0, 0, 1));
    wr(a_cfg(21), cfgw(2, 0, 1, 0, 0, 1));
    wr(a_cfg(22), cfgw(2, 0, 1, 0, 0, 0));
    pad_i[22] = 1'b1;
    idle(4);
    rd(A_VAL, 32'h0050_0000, 32'h0070_0000, "R9 value picks drive or input");
    rd(a_cfg(22), cfgw(2, 0, 1, 0, 0, 0) | 32'h2, '1, "R9 rx state bit");
    chk(pad_o[20], 1, "R10 drive out");
    chk(pad_oe_o[20], 1, "R10 oe on");
    chk(pad_oe_o[21], 0, "R10 oe off when tx disabled");

    idle(3);
    finish_run();
  end

endmodule